// File: doc/BRIEF.md
# Two-Wire Register-File Target with Pointer Auto-Increment

This block is a target device on a two-wire serial bus (I2C). It samples the clock and data lines through synchronizers and a glitch filter and finds start, repeated start and stop conditions. It takes in the 7-bit address byte and acknowledges when the address matches its own. It then serves a small array of byte-wide registers through an internal pointer.

In a write, the first byte after the address picks the register pointer. Every byte after that lands at the pointer, which then steps by one. In a read, the target shifts out the register at the pointer and steps after each byte. The pointer is not cleared by a repeated start, so a host can write the pointer and then read from it after a restart.

Both lines are driven in open-drain fashion: an enable output of 1 pulls the line low. A stretch-request input lets the surrounding logic hold the clock low at the start of any read byte.

Top module: `i2c_regfile_slave`

## Requirements
- R1: The first byte after a start holds the address in bits 7:1 and the direction in bit 0 (0 = host writes, 1 = host reads). When bits 7:1 equal the parameter DEV_ADDR, the target pulls SDA low for the whole of the ninth clock.
- R2: When the address does not match, the target leaves SDA released (the host sees a NACK). The rest of that transfer changes no register.
- R3: In a write, the low 4 bits of the first data byte become the pointer. Each later byte is stored at the pointer and the pointer then steps by one. Every data byte is acknowledged.
- R4: In a read, the target sends the register at the pointer MSB first, with one bit per clock. The pointer steps by one after each byte.
- R5: A repeated start or a new start keeps the pointer. A read with no pointer byte in front of it begins where the previous access left off.
- R6: When the host answers a read byte with a NACK (SDA high on the ninth clock), the target stops sending and leaves SDA released.
- R7: A stop (SDA rising while SCL is high) ends any transfer at any bit, even mid-byte. A partial byte is discarded and SDA is released.
- R8: The target changes its SDA drive only while SCL is low.
- R9: The pointer wraps from 15 to 0, on both write and read.
- R10: If the stretch request is high when a read byte begins, SCL is held low until the request falls. The byte that follows is correct.
- R11: After reset both line enables are 0, every register reads 0 and the pointer is 0.
- R12: A low pulse on SDA lasting one system clock while SCL is high is filtered out. It is not taken as a start or stop, and it does not corrupt the byte in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled level of the SCL line |
| sda_i | input | 1 | Sampled level of the SDA line |
| stretch_req_i | input | 1 | Asks that SCL be held low at the start of a read byte |
| scl_oe_o | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe_o | output | 1 | 1 pulls SDA low (acknowledge or a read data 0) |

## Verification
The assertions assume that each SCL low phase lasts longer than the synchronizer and filter delay of about six system clocks. Under that assumption, a change of the SDA drive made at a filtered falling edge still falls while the real line is low. They also assume the host never issues a start or stop while the target holds SDA low.

The bench host uses quarter-bit phases of ten system clocks. It changes SDA only in the middle of the low phase and ends reads with a NACK before any restart or stop, which keeps to those assumptions. The random transfers mix pointer values above 15, lengths that cross the wrap and reads with and without a pointer byte in front.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WR,
    ST_WACK,
    ST_RD,
    ST_RACK
  } rf_state_e;
endpackage

// File: rtl/i2c_rf_filt.sv
module i2c_rf_filt #(
  parameter int unsigned FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic pin_o
);
  logic                s1_q, s2_q, out_q, out_n;
  logic [FILT_LEN-1:0] hist_q, hist_n;

  always_comb begin
    hist_n = {hist_q[FILT_LEN-2:0], s2_q};
    out_n  = out_q;
    if (&hist_q)       out_n = 1'b1;
    else if (~|hist_q) out_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      hist_q <= '1;
      out_q  <= 1'b1;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      hist_q <= hist_n;
      out_q  <= out_n;
    end
  end

  assign pin_o = out_q;
endmodule

// File: rtl/i2c_rf_regs.sv
module i2c_rf_regs #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic [PTR_W-1:0] rd_idx,
  output logic [7:0]       rd_data
);
  logic [DEPTH-1:0][7:0] cells;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic [7:0] cell_q;
    logic       hit;
    assign hit = wr_en && (wr_idx == PTR_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cell_q <= '0;
      else if (hit) cell_q <= wr_data;
    end
    assign cells[i] = cell_q;
  end

  assign rd_data = cells[rd_idx];
endmodule

// File: rtl/i2c_rf_ctrl.sv
module i2c_rf_ctrl
  import i2c_rf_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'h2A,
  parameter int unsigned DEPTH    = 16,
  parameter int unsigned PTR_W    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_f,
  input  logic             sda_f,
  input  logic             stretch_req_i,
  input  logic [7:0]       rd_data,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic [PTR_W-1:0] ptr_o,
  output logic             ptr_inc_o,
  output logic             start_o,
  output logic             stop_o,
  output logic             sda_oe_o,
  output logic             scl_oe_o
);
  rf_state_e        state_q, state_n;
  logic [3:0]       cnt_q, cnt_n;
  logic [7:0]       rx_q, rx_n, tx_q, tx_n;
  logic [PTR_W-1:0] ptr_q, ptr_n;
  logic             ptr_set_q, ptr_set_n;
  logic             rw_q, rw_n, ack_q, ack_n;
  logic             sda_oe_q, sda_oe_n, str_q, str_n;
  logic             scl_d_q, sda_d_q;
  logic             scl_rise, scl_fall, start_det, stop_det, byte_end;

  assign scl_rise  = scl_f & ~scl_d_q;
  assign scl_fall  = ~scl_f & scl_d_q;
  assign start_det = scl_f & scl_d_q & sda_d_q & ~sda_f;
  assign stop_det  = scl_f & scl_d_q & ~sda_d_q & sda_f;
  assign byte_end  = scl_fall && (cnt_q == 4'd8);

  always_comb begin
    state_n   = state_q;
    cnt_n     = cnt_q;
    rx_n      = rx_q;
    tx_n      = tx_q;
    ptr_n     = ptr_q;
    ptr_set_n = ptr_set_q;
    rw_n      = rw_q;
    ack_n     = ack_q;
    sda_oe_n  = sda_oe_q;
    str_n     = str_q & stretch_req_i;
    wr_en     = 1'b0;
    ptr_inc_o = 1'b0;
    if (stop_det) begin
      state_n  = ST_IDLE;
      sda_oe_n = 1'b0;
      str_n    = 1'b0;
    end else if (start_det) begin
      state_n   = ST_ADDR;
      cnt_n     = '0;
      sda_oe_n  = 1'b0;
      ptr_set_n = 1'b0;
      str_n     = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: ;
        ST_ADDR, ST_WR: begin
          if (scl_rise) begin
            rx_n  = {rx_q[6:0], sda_f};
            cnt_n = cnt_q + 4'd1;
          end
          if (byte_end) begin
            if (state_q == ST_ADDR) begin
              if (rx_q[7:1] == DEV_ADDR) begin
                state_n  = ST_AACK;
                sda_oe_n = 1'b1;
                rw_n     = rx_q[0];
              end else begin
                state_n = ST_IDLE;
              end
            end else begin
              state_n  = ST_WACK;
              sda_oe_n = 1'b1;
              if (!ptr_set_q) begin
                ptr_n     = rx_q[PTR_W-1:0];
                ptr_set_n = 1'b1;
              end else begin
                wr_en     = 1'b1;
                ptr_inc_o = 1'b1;
                ptr_n     = ptr_q + PTR_W'(1);
              end
            end
          end
        end
        ST_AACK, ST_WACK: begin
          if (scl_fall) begin
            cnt_n = '0;
            if (state_q == ST_AACK && rw_q) begin
              state_n  = ST_RD;
              tx_n     = rd_data;
              sda_oe_n = ~rd_data[7];
              str_n    = stretch_req_i;
            end else begin
              state_n  = ST_WR;
              sda_oe_n = 1'b0;
            end
          end
        end
        ST_RD: begin
          if (scl_rise) cnt_n = cnt_q + 4'd1;
          if (byte_end) begin
            state_n   = ST_RACK;
            sda_oe_n  = 1'b0;
            ptr_inc_o = 1'b1;
            ptr_n     = ptr_q + PTR_W'(1);
          end else if (scl_fall) begin
            tx_n     = {tx_q[6:0], 1'b0};
            sda_oe_n = ~tx_q[6];
          end
        end
        ST_RACK: begin
          if (scl_rise) ack_n = ~sda_f;
          if (scl_fall) begin
            if (ack_q) begin
              state_n  = ST_RD;
              cnt_n    = '0;
              tx_n     = rd_data;
              sda_oe_n = ~rd_data[7];
              str_n    = stretch_req_i;
            end else begin
              state_n = ST_IDLE;
            end
          end
        end
        default: state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      ptr_q     <= '0;
      ptr_set_q <= 1'b0;
      rw_q      <= 1'b0;
      ack_q     <= 1'b0;
      sda_oe_q  <= 1'b0;
      str_q     <= 1'b0;
      scl_d_q   <= 1'b1;
      sda_d_q   <= 1'b1;
    end else begin
      state_q   <= state_n;
      cnt_q     <= cnt_n;
      rx_q      <= rx_n;
      tx_q      <= tx_n;
      ptr_q     <= ptr_n;
      ptr_set_q <= ptr_set_n;
      rw_q      <= rw_n;
      ack_q     <= ack_n;
      sda_oe_q  <= sda_oe_n;
      str_q     <= str_n;
      scl_d_q   <= scl_f;
      sda_d_q   <= sda_f;
    end
  end

  assign wr_idx   = ptr_q;
  assign wr_data  = rx_q;
  assign ptr_o    = ptr_q;
  assign start_o  = start_det;
  assign stop_o   = stop_det;
  assign sda_oe_o = sda_oe_q;
  assign scl_oe_o = str_q;
endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave #(
  parameter logic [6:0]  DEV_ADDR = 7'h2A,
  parameter int unsigned DEPTH    = 16,
  parameter int unsigned FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic stretch_req_i,
  output logic scl_oe_o,
  output logic sda_oe_o
);
  localparam int unsigned PTR_W  = $clog2(DEPTH);
  localparam int unsigned N_PINS = 2;

  logic [1:0]        rst_pipe_q;
  logic              rst_int_n;
  logic [N_PINS-1:0] pins_raw, pins_f;
  logic              scl_f, sda_f;
  logic              wr_en, ptr_inc, start_det, stop_det;
  logic [PTR_W-1:0]  wr_idx, ptr;
  logic [7:0]        wr_data, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  assign pins_raw = {sda_i, scl_i};
  for (genvar g = 0; g < N_PINS; g++) begin : g_filt
    i2c_rf_filt #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk   (clk),
      .rst_n (rst_int_n),
      .pin_i (pins_raw[g]),
      .pin_o (pins_f[g])
    );
  end
  assign scl_f = pins_f[0];
  assign sda_f = pins_f[1];

  i2c_rf_ctrl #(.DEV_ADDR(DEV_ADDR), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .scl_f         (scl_f),
    .sda_f         (sda_f),
    .stretch_req_i (stretch_req_i),
    .rd_data       (rd_data),
    .wr_en         (wr_en),
    .wr_idx        (wr_idx),
    .wr_data       (wr_data),
    .ptr_o         (ptr),
    .ptr_inc_o     (ptr_inc),
    .start_o       (start_det),
    .stop_o        (stop_det),
    .sda_oe_o      (sda_oe_o),
    .scl_oe_o      (scl_oe_o)
  );

  i2c_rf_regs #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (ptr),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/i2c_rf_chk.sv
module i2c_rf_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned PTR_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_i,
  input logic             sda_oe_o,
  input logic             scl_oe_o,
  input logic             stretch_req_i,
  input logic             start_det,
  input logic             stop_det,
  input logic [PTR_W-1:0] ptr,
  input logic             ptr_inc
);
  // R8: SDA drive moves only while the bus clock is low
  a_r8_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_i);

  // R7: a stop leaves SDA released
  a_r7_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe_o);

  // R5: a start (or restart) also leaves SDA released
  a_r5_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe_o);

  // R10: clock is held only while the stretch request was present
  a_r10_stretch_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe_o |-> $past(stretch_req_i));

  // R9: the pointer wraps to zero after the last location
  a_r9_ptr_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_inc && ptr == PTR_W'(DEPTH - 1)) |=> (ptr == '0));
endmodule

bind i2c_regfile_slave i2c_rf_chk #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .scl_i         (scl_i),
  .sda_oe_o      (sda_oe_o),
  .scl_oe_o      (scl_oe_o),
  .stretch_req_i (stretch_req_i),
  .start_det     (start_det),
  .stop_det      (stop_det),
  .ptr           (ptr),
  .ptr_inc       (ptr_inc)
);

// File: tb/i2c_regfile_slave_tb.sv
module i2c_regfile_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 10;
  localparam logic [6:0] ADDR = 7'h2A;
  localparam logic [7:0] AW = {ADDR, 1'b0};
  localparam logic [7:0] AR = {ADDR, 1'b1};

  logic clk, rst_n, m_scl, m_sda, glitch, stretch_req;
  logic scl_oe, sda_oe;
  wire  scl_bus = m_scl & ~scl_oe;
  wire  sda_bus = m_sda & ~sda_oe & ~glitch;

  int tests, fails, r8_viol;
  logic [7:0] mem [16];
  int mptr;

  i2c_regfile_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .stretch_req_i(stretch_req), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic sda_oe_d;
  always @(negedge clk) begin
    if (rst_n && (sda_oe !== sda_oe_d) && scl_bus) r8_viol++;
    sda_oe_d <= sda_oe;
  end

  function automatic int nxt(input int p);
    return (p + 1) % 16;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    m_sda = 1'b1; m_scl = 1'b1; w(2*Q);
    m_sda = 1'b0; w(2*Q);
    m_scl = 1'b0;
  endtask

  task automatic do_restart();
    w(Q); m_sda = 1'b1; w(Q);
    m_scl = 1'b1; w(2*Q);
    m_sda = 1'b0; w(2*Q);
    m_scl = 1'b0;
  endtask

  task automatic do_stop();
    w(Q); m_sda = 1'b0; w(Q);
    m_scl = 1'b1; w(2*Q);
    m_sda = 1'b1; w(2*Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits, input int gbit);
    for (int i = 7; i > 7 - nbits; i--) begin
      w(Q); m_sda = b[i]; w(Q);
      m_scl = 1'b1;
      wait (scl_bus);
      w(Q);
      if (i == gbit) begin glitch = 1'b1; w(1); glitch = 1'b0; w(Q-1); end
      else w(Q);
      m_scl = 1'b0;
    end
  endtask

  task automatic wbyte(input logic [7:0] b, input int gbit, output bit ack);
    send_bits(b, 8, gbit);
    w(Q); m_sda = 1'b1; w(Q);
    m_scl = 1'b1; w(Q);
    ack = ~sda_bus; w(Q);
    m_scl = 1'b0;
  endtask

  task automatic rbyte(input bit give_ack, output logic [7:0] b);
    b = '0;
    m_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      w(2*Q);
      m_scl = 1'b1;
      wait (scl_bus);
      w(Q); b = {b[6:0], sda_bus}; w(Q);
      m_scl = 1'b0;
    end
    w(Q); m_sda = give_ack ? 1'b0 : 1'b1; w(Q);
    m_scl = 1'b1; w(2*Q);
    m_scl = 1'b0; w(Q);
    m_sda = 1'b1;
  endtask

  task automatic wr_seq(input int p, input int n);
    bit ack;
    logic [7:0] d;
    do_start();
    wbyte(AW, -1, ack); chk(ack, "R1 address ack", ack, 1);
    wbyte(8'(p), -1, ack); chk(ack, "R3 pointer ack", ack, 1);
    mptr = p % 16;
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      wbyte(d, -1, ack); chk(ack, "R3 data ack", ack, 1);
      mem[mptr] = d; mptr = nxt(mptr);
    end
    do_stop();
  endtask

  task automatic rd_seq(input int p, input int n, input bit set_ptr, input string tag);
    bit ack;
    logic [7:0] b;
    do_start();
    if (set_ptr) begin
      wbyte(AW, -1, ack); chk(ack, "R1 address ack", ack, 1);
      wbyte(8'(p), -1, ack); chk(ack, "R3 pointer ack", ack, 1);
      mptr = p % 16;
      do_restart();
    end
    wbyte(AR, -1, ack); chk(ack, "R1 read address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      rbyte(k < n - 1, b);
      chk(b === mem[mptr], tag, b, mem[mptr]);
      mptr = nxt(mptr);
    end
    chk(sda_oe === 1'b0 && sda_bus === 1'b1, "R6 released after NACK", sda_oe, 0);
    do_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] b;
    void'($urandom(32'd1357));
    tests = 0; fails = 0; r8_viol = 0;
    m_scl = 1'b1; m_sda = 1'b1; glitch = 1'b0; stretch_req = 1'b0;
    sda_oe_d = 1'b0;
    for (int i = 0; i < 16; i++) mem[i] = '0;
    mptr = 0;
    rst_n = 1'b0;
    w(5);
    rst_n = 1'b1;
    w(10);
    chk(scl_oe === 1'b0, "R11 scl_oe after reset", scl_oe, 0);
    chk(sda_oe === 1'b0, "R11 sda_oe after reset", sda_oe, 0);

    // R11 registers and pointer zero: read without pointer byte from 0
    rd_seq(0, 3, 1'b0, "R11 reset contents");

    // R3/R4 write then read back
    wr_seq(3, 4);
    rd_seq(3, 4, 1'b1, "R4 readback");

    // R5 pointer survives: continue reading without pointer byte
    rd_seq(0, 2, 1'b0, "R5 continued read");

    // R9 wrap on write and read, pointer byte above 15 uses low 4 bits (R3)
    wr_seq(8'hEE, 4);
    rd_seq(14, 4, 1'b1, "R9 wrap readback");

    // R2 mismatch address: NACK and no write
    do_start();
    wbyte(8'h66, -1, ack); chk(!ack, "R2 mismatch NACK", ack, 0);
    wbyte(8'h03, -1, ack); chk(!ack, "R2 no ack after mismatch", ack, 0);
    wbyte(8'hA5, -1, ack);
    do_stop();
    rd_seq(3, 1, 1'b1, "R2 register unchanged");

    // R7 stop in the middle of a data byte
    do_start();
    wbyte(AW, -1, ack); chk(ack, "R7 address ack", ack, 1);
    wbyte(8'h05, -1, ack);
    send_bits(8'h3C, 3, -1);
    do_stop();
    chk(sda_oe === 1'b0, "R7 sda released after stop", sda_oe, 0);
    rd_seq(5, 1, 1'b1, "R7 partial byte dropped");

    // R12 one-clock SDA glitch while SCL high on a 1 bit
    do_start();
    wbyte(AW, -1, ack);
    wbyte(8'h06, -1, ack);
    wbyte(8'hF7, 5, ack); chk(ack, "R12 byte acked through glitch", ack, 1);
    do_stop();
    mem[6] = 8'hF7;
    rd_seq(6, 1, 1'b1, "R12 glitch filtered");

    // R10 clock stretch at start of read byte
    wr_seq(10, 2);
    do_start();
    wbyte(AW, -1, ack);
    wbyte(8'd10, -1, ack);
    mptr = 10;
    do_restart();
    stretch_req = 1'b1;
    wbyte(AR, -1, ack); chk(ack, "R10 read address ack", ack, 1);
    w(2*Q);
    chk(scl_oe === 1'b1, "R10 stretch active", scl_oe, 1);
    fork
      rbyte(1'b0, b);
      begin
        w(6*Q);
        chk(scl_bus === 1'b0, "R10 SCL held low", scl_bus, 0);
        stretch_req = 1'b0;
      end
    join
    chk(b === mem[10], "R10 data after stretch", b, mem[10]);
    mptr = nxt(mptr);
    do_stop();

    // random mix
    for (int t = 0; t < 20; t++) begin
      if ($urandom % 2 == 0) wr_seq(int'($urandom % 256), 1 + int'($urandom % 4));
      else rd_seq(int'($urandom % 256), 1 + int'($urandom % 4), ($urandom % 3) != 0, "R4 random read");
    end

    chk(r8_viol == 0, "R8 SDA change while SCL high", r8_viol, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule